// File: doc/BRIEF.md
# I2S Stereo Audio Receiver

This block takes a three-wire I2S stream (bit clock, word select, serial data) and turns it into 16-bit left/right sample pairs for a 48 kHz stereo audio path. It can own the bus timing or follow it. With `master_en` high it divides the system clock down to make the bit clock and word select itself. With `master_en` low it takes both from external pins, passes them through a synchronizer into the system clock domain, and finds their edges there. The mode can change at run time. After a change, capture starts again from a clean state.

Serial data changes on the falling edge of the bit clock, MSB first. It lags each word-select change by one bit clock, and the receiver samples it on rising edges. Word select low carries the left channel and high carries the right. `long_slot` sets the slot length in master mode to 16 or 32 bit clocks per channel. The sample width stays 16 bits, so in long slots the bits after the sixteenth are dropped. Once the right word of a pair is complete, both samples are presented together with a one-cycle `pair_valid` strobe.

Top module: `i2s_stereo_rx`

## Requirements
- R1: During and right after reset, `bclk_out`, `ws_out`, `pair_valid`, `left_sample` and `right_sample` are all zero.
- R2: In master mode `bclk_out` stays high for HALF_DIV system clock cycles, then low for HALF_DIV cycles, so one bit-clock period is 2*HALF_DIV cycles.
- R3: In master mode `ws_out` is low for one slot and high for the next. A slot is 16 bit clocks with `long_slot`=0 and 32 with `long_slot`=1, so a frame is 32 or 64 bit clocks. `ws_out` changes only on a cycle where `bclk_out` has just fallen.
- R4: In slave mode (`master_en`=0), from the second cycle on, `bclk_out` and `ws_out` stay low. The receiver then times itself from `bclk_in` and `ws_in` after synchronizing them, and the slot length follows `ws_in`.
- R5: A word starts at the second bit-clock rising edge after word select changes (a one-bit lag). The bit sampled there is the MSB, and the next 15 rising edges give the rest down to the LSB.
- R6: A word captured while word select was low (during the previous bit) goes to `left_sample`, and one captured while it was high goes to `right_sample`.
- R7: With 32-bit slots, the serial data bits after the sixteenth in each slot have no effect on the samples.
- R8: `pair_valid` is high for exactly one cycle after each right word completes, but only if a left word completed since the previous pair. `left_sample` and `right_sample` change only in a cycle where `pair_valid` is high.
- R9: After reset or a mode change, no word is captured until a word-select change has been seen after at least two bit-clock rising edges. Bits before that never reach the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: generate the bit clock and word select; 0: follow the external ones |
| long_slot | input | 1 | Master slot length: 0 = 16 bit clocks, 1 = 32 bit clocks per channel |
| bclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 1 | Serial data, MSB first |
| bclk_out | output | 1 | Generated bit clock (master mode, else low) |
| ws_out | output | 1 | Generated word select (master mode, else low) |
| left_sample | output | 16 | Left sample of the last pair |
| right_sample | output | 16 | Right sample of the last pair |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
If the bit counter or word-select tracking drifts, the next pair comes out shifted by one bit or with its channels swapped. That shows as a wrong `left_sample`/`right_sample` value on the first `pair_valid` after the fault, within one frame. A broken lock or left-pending flag shows up as a missing or extra `pair_valid` compared with the frames sent. A faulty divider or slot counter in master mode changes the `bclk_out` period or the number of bit clocks between `ws_out` edges, which is visible within one bit clock or one frame. Directed extreme words (sign bit only, maximum positive, all ones, LSB only) and random garbage in the unused half of long slots make bit-order and discard faults visible.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/1ps
package i2s_rx_pkg;

   // channel carried by a slot, taken from word select
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   // one bit-clock event in the system clock domain
   typedef struct packed {
      logic rise;   // bit clock rising edge this cycle
      logic ws;     // word select as seen at that edge
      logic sd;     // serial data as seen at that edge
   } rx_bit_t;

endpackage

// File: rtl/i2s_rx_clkgen.sv
`timescale 1ns/1ps
module i2s_rx_clkgen #(
   parameter int HALF_DIV   = 4,
   parameter int SHORT_SLOT = 16,
   parameter int LONG_SLOT  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic long_slot,
   output logic bclk,
   output logic ws,
   output logic rise_stb
);
   localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int IDX_W = $clog2(2 * LONG_SLOT);
   localparam logic [DIV_W-1:0] DIV_LAST   = DIV_W'(HALF_DIV - 1);
   localparam logic [IDX_W-1:0] SHORT_LEN  = IDX_W'(SHORT_SLOT);
   localparam logic [IDX_W-1:0] LONG_LEN   = IDX_W'(LONG_SLOT);
   localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(2 * SHORT_SLOT - 1);
   localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(2 * LONG_SLOT - 1);

   logic [DIV_W-1:0] div_q;
   logic [IDX_W-1:0] idx_q, idx_nxt, slot_len, frame_last;
   logic             div_end;

   assign div_end    = (div_q == DIV_LAST);
   assign slot_len   = long_slot ? LONG_LEN  : SHORT_LEN;
   assign frame_last = long_slot ? LONG_LAST : SHORT_LAST;
   assign idx_nxt    = (idx_q >= frame_last) ? '0 : idx_q + 1'b1;
   assign rise_stb   = en && div_end && !bclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         idx_q <= '0;
         bclk  <= 1'b0;
         ws    <= 1'b0;
      end else if (!en) begin
         div_q <= '0;
         idx_q <= '0;
         bclk  <= 1'b0;
         ws    <= 1'b0;
      end else if (div_end) begin
         div_q <= '0;
         bclk  <= !bclk;
         if (bclk) begin
            // falling edge: advance the bit position, move word select
            idx_q <= idx_nxt;
            ws    <= (idx_nxt >= slot_len);
         end
      end else begin
         div_q <= div_q + 1'b1;
      end
   end
endmodule

// File: rtl/i2s_rx_sync.sv
`timescale 1ns/1ps
module i2s_rx_sync
   import i2s_rx_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    bclk_in,
   input  logic    ws_in,
   input  logic    sd_in,
   output rx_bit_t evt
);
   logic [2:0] line_s;   // {bclk, ws, sd} after the last stage
   logic       bclk_d;

   generate
      if (STAGES == 1) begin : g_single
         logic [2:0] st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= {bclk_in, ws_in, sd_in};
         end
         assign line_s = st_q;
      end else begin : g_chain
         logic [STAGES-1:0][2:0] st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= {st_q[STAGES-2:0], {bclk_in, ws_in, sd_in}};
         end
         assign line_s = st_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= line_s[2];
   end

   assign evt.rise = line_s[2] && !bclk_d;
   assign evt.ws   = line_s[1];
   assign evt.sd   = line_s[0];
endmodule

// File: rtl/i2s_rx_deser.sv
`timescale 1ns/1ps
module i2s_rx_deser
   import i2s_rx_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  rx_bit_t             evt,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   localparam int CNT_W = $clog2(SAMPLE_W + 1);
   localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(SAMPLE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

   logic                ws_q1, ws_q2;     // word select one and two edges back
   logic [1:0]          seen_q;           // edges since restart, saturating
   logic [CNT_W-1:0]    cnt_q;
   logic [SAMPLE_W-1:0] shreg_q, word_nxt, left_hold_q;
   logic                left_ok_q;
   chan_e               chan_q;
   logic                slot_start;

   assign slot_start = (seen_q == 2'd2) && (ws_q1 != ws_q2);
   assign word_nxt   = {shreg_q[SAMPLE_W-2:0], evt.sd};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_q1       <= 1'b0;
         ws_q2       <= 1'b0;
         seen_q      <= '0;
         cnt_q       <= CNT_IDLE;
         shreg_q     <= '0;
         left_hold_q <= '0;
         left_ok_q   <= 1'b0;
         chan_q      <= CH_LEFT;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (restart) begin
            ws_q1     <= 1'b0;
            ws_q2     <= 1'b0;
            seen_q    <= '0;
            cnt_q     <= CNT_IDLE;
            left_ok_q <= 1'b0;
         end else if (evt.rise) begin
            ws_q1 <= evt.ws;
            ws_q2 <= ws_q1;
            if (seen_q != 2'd2) seen_q <= seen_q + 1'b1;
            if (slot_start) begin
               shreg_q <= word_nxt;
               cnt_q   <= CNT_W'(1);
               chan_q  <= chan_e'(ws_q1);
            end else if (cnt_q < CNT_IDLE) begin
               shreg_q <= word_nxt;
               cnt_q   <= cnt_q + 1'b1;
               if (cnt_q == CNT_LAST) begin
                  if (chan_q == CH_LEFT) begin
                     left_hold_q <= word_nxt;
                     left_ok_q   <= 1'b1;
                  end else if (left_ok_q) begin
                     left_o    <= left_hold_q;
                     right_o   <= word_nxt;
                     valid_o   <= 1'b1;
                     left_ok_q <= 1'b0;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2s_stereo_rx.sv
`timescale 1ns/1ps
module i2s_stereo_rx
   import i2s_rx_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int SHORT_SLOT  = 16,
   parameter int LONG_SLOT   = 32,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                master_en,
   input  logic                long_slot,
   input  logic                bclk_in,
   input  logic                ws_in,
   input  logic                sd_in,
   output logic                bclk_out,
   output logic                ws_out,
   output logic [SAMPLE_W-1:0] left_sample,
   output logic [SAMPLE_W-1:0] right_sample,
   output logic                pair_valid
);
   generate
      if (SAMPLE_W < 2)           begin : g_bad_w    $error("SAMPLE_W must be at least 2");          end
      if (SAMPLE_W > SHORT_SLOT)  begin : g_bad_slot $error("SAMPLE_W must fit in a short slot");    end
      if (LONG_SLOT <= SHORT_SLOT) begin : g_bad_lng $error("LONG_SLOT must exceed SHORT_SLOT");     end
      if (HALF_DIV < 2)           begin : g_bad_div  $error("HALF_DIV must be at least 2");          end
      if (SYNC_STAGES < 1)        begin : g_bad_sync $error("SYNC_STAGES must be at least 1");       end
   endgenerate

   logic    mode_q, restart;
   logic    gen_rise;
   rx_bit_t slave_evt, sel_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= master_en;
   end
   assign restart = (mode_q != master_en);

   i2s_rx_clkgen #(
      .HALF_DIV  (HALF_DIV),
      .SHORT_SLOT(SHORT_SLOT),
      .LONG_SLOT (LONG_SLOT)
   ) clkgen_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (master_en),
      .long_slot(long_slot),
      .bclk     (bclk_out),
      .ws       (ws_out),
      .rise_stb (gen_rise)
   );

   i2s_rx_sync #(
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .bclk_in(bclk_in),
      .ws_in  (ws_in),
      .sd_in  (sd_in),
      .evt    (slave_evt)
   );

   always_comb begin
      if (master_en) begin
         sel_evt.rise = gen_rise;
         sel_evt.ws   = ws_out;
         sel_evt.sd   = sd_in;
      end else begin
         sel_evt = slave_evt;
      end
   end

   i2s_rx_deser #(
      .SAMPLE_W(SAMPLE_W)
   ) deser_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .evt    (sel_evt),
      .left_o (left_sample),
      .right_o(right_sample),
      .valid_o(pair_valid)
   );
endmodule

// File: rtl/i2s_stereo_rx_chk.sv
`timescale 1ns/1ps
module i2s_stereo_rx_chk #(
   parameter int SAMPLE_W = 16,
   parameter int HALF_DIV = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                master_en,
   input logic                bclk_out,
   input logic                ws_out,
   input logic [SAMPLE_W-1:0] left_sample,
   input logic [SAMPLE_W-1:0] right_sample,
   input logic                pair_valid
);
   localparam int CW = $clog2(HALF_DIV) + 2;

   logic          bclk_prev;
   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_prev <= 1'b0;
         run_cnt   <= '0;
      end else begin
         bclk_prev <= bclk_out;
         if (!master_en)                run_cnt <= '0;
         else if (bclk_out != bclk_prev) run_cnt <= CW'(1);
         else                           run_cnt <= run_cnt + 1'b1;
      end
   end

   AST_BCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (master_en && (bclk_out != bclk_prev)) |-> (run_cnt == CW'(HALF_DIV))); // R2

   AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (master_en && $past(master_en) && (ws_out != $past(ws_out)))
         |-> (!bclk_out && $past(bclk_out))); // R3

   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_en && $past(!master_en)) |-> (!bclk_out && !ws_out)); // R4

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !pair_valid); // R8

   AST_HOLD_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
      ((left_sample != $past(left_sample)) || (right_sample != $past(right_sample)))
         |-> pair_valid); // R8
endmodule

bind i2s_stereo_rx i2s_stereo_rx_chk #(
   .SAMPLE_W(SAMPLE_W),
   .HALF_DIV(HALF_DIV)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .master_en   (master_en),
   .bclk_out    (bclk_out),
   .ws_out      (ws_out),
   .left_sample (left_sample),
   .right_sample(right_sample),
   .pair_valid  (pair_valid)
);

// File: tb/i2s_stereo_rx_tb_top.sv
`timescale 1ns/1ps
module i2s_stereo_rx_tb_top;
   localparam int CLK_NS   = 5;
   localparam int HALF_DIV = 4;
   localparam int SL_HALF  = 30;   // slave bit clock half period in ns

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_en = 1'b1;
   logic        long_slot = 1'b0;
   logic        bclk_in = 1'b0;
   logic        ws_in = 1'b0;
   logic        sd_in = 1'b0;
   logic        bclk_out, ws_out, pair_valid;
   logic [15:0] left_sample, right_sample;

   int errors = 0;
   int checks = 0;
   int received = 0;
   string pair_tag = "R5/R6";
   logic [31:0] exp_q[$];

   // transmitter model state
   logic        tx_prev_ws;
   logic [15:0] tx_word, tx_left;
   int          tx_pos;
   bit          tx_valid;
   int          word_idx = 0;

   always #(CLK_NS / 2.0) clk = !clk;

   i2s_stereo_rx #(.HALF_DIV(HALF_DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .long_slot(long_slot),
      .bclk_in(bclk_in), .ws_in(ws_in), .sd_in(sd_in),
      .bclk_out(bclk_out), .ws_out(ws_out),
      .left_sample(left_sample), .right_sample(right_sample), .pair_valid(pair_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic next_word(output logic [15:0] w);
      case (word_idx)
         0: w = 16'h8000;
         1: w = 16'h7FFF;
         2: w = 16'hFFFF;
         3: w = 16'h0001;
         default: w = 16'($urandom);
      endcase
      word_idx++;
   endtask

   task automatic tx_reset();
      tx_prev_ws = 1'b0;
      tx_word    = '0;
      tx_left    = '0;
      tx_pos     = 100;
      tx_valid   = 1'b0;
   endtask

   // one falling bit-clock edge: returns the data bit to drive
   task automatic tx_fall(input logic ws_now, output logic b);
      logic [15:0] nw;
      if (tx_pos < 100) tx_pos++;
      if (tx_pos >= 1 && tx_pos <= 16) b = tx_word[16 - tx_pos];
      else                             b = 1'($urandom_range(1, 0));
      if (ws_now != tx_prev_ws) begin
         next_word(nw);
         if (ws_now) begin
            if (tx_valid) exp_q.push_back({tx_word, nw});
         end
         tx_word    = nw;
         tx_valid   = 1'b1;
         tx_pos     = 0;
         tx_prev_ws = ws_now;
      end
   endtask

   // pair monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n && pair_valid) begin
         received++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "pair without a complete left/right frame",
                  {left_sample, right_sample}, 32'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check({left_sample, right_sample} == e, pair_tag, "left/right pair",
                  {left_sample, right_sample}, e);
         end
      end
   end

   task automatic do_reset(input logic mode, input logic lslot);
      rst_n     = 1'b0;
      master_en = mode;
      long_slot = lslot;
      bclk_in   = 1'b0;
      ws_in     = 1'b0;
      sd_in     = 1'b0;
      repeat (4) @(posedge clk);
      tx_reset();
      exp_q.delete();
      @(negedge clk);
      rst_n    = 1'b1;
      received = 0;
   endtask

   task automatic run_master(input int nframes, input int slot);
      int   rises = 0;
      int   falls = 0;
      int   periods = 0;
      bit   have_ws = 0;
      bit   have_t = 0;
      logic ws_prev = 1'b0;
      logic b;
      time  t_prev = 0;
      while (rises < nframes + 1) begin
         @(negedge bclk_out);
         if (have_t && periods < 12) begin
            periods++;
            check(($time - t_prev) == 2 * HALF_DIV * CLK_NS, "R2", "bit clock period",
                  32'($time - t_prev), 32'(2 * HALF_DIV * CLK_NS));
         end
         t_prev = $time;
         have_t = 1;
         #1;
         tx_fall(ws_out, b);
         sd_in = b;
         falls++;
         if (ws_out != ws_prev) begin
            check(bclk_out == 1'b0, "R3", "bit clock low at word select change",
                  32'(bclk_out), 32'h0);
            if (ws_out) begin
               if (have_ws)
                  check(falls == 2 * slot, "R3", "bit clocks per frame", 32'(falls), 32'(2 * slot));
               have_ws = 1;
               falls   = 0;
               rises++;
            end else if (have_ws) begin
               check(falls == slot, "R3", "bit clocks in right slot", 32'(falls), 32'(slot));
            end
         end
         ws_prev = ws_out;
      end
      repeat (20) @(negedge clk);
      check(exp_q.size() <= 1, "R8", "pairs left undelivered", 32'(exp_q.size()), 32'h1);
      check(received >= nframes - 1, "R8", "pairs delivered", 32'(received), 32'(nframes - 1));
   endtask

   task automatic run_slave(input int nframes, input int slot, input logic pre_ws);
      logic b;
      for (int i = 0; i < 20; i++) begin
         bclk_in = 1'b0;
         ws_in   = pre_ws;
         tx_fall(pre_ws, b);
         sd_in   = b;
         #(SL_HALF);
         bclk_in = 1'b1;
         #(SL_HALF);
      end
      check(received == 0, "R9", "no pair before a word select change", 32'(received), 32'h0);
      for (int f = 0; f < nframes + 1; f++) begin
         for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < slot; k++) begin
               bclk_in = 1'b0;
               ws_in   = 1'(ch);
               tx_fall(1'(ch), b);
               sd_in   = b;
               #(SL_HALF);
               bclk_in = 1'b1;
               if (k == 0 && f < 3)
                  check(!bclk_out && !ws_out, "R4", "generated lines quiet in slave mode",
                        {30'h0, bclk_out, ws_out}, 32'h0);
               #(SL_HALF);
            end
         end
      end
      repeat (20) @(negedge clk);
      check(exp_q.size() <= 1, "R8", "pairs left undelivered", 32'(exp_q.size()), 32'h1);
      check(received >= nframes - 1, "R8", "pairs delivered", 32'(received), 32'(nframes - 1));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      tx_reset();
      // reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check({bclk_out, ws_out, pair_valid} == 3'b000, "R1", "control outputs in reset",
            {29'h0, bclk_out, ws_out, pair_valid}, 32'h0);
      check({left_sample, right_sample} == 32'h0, "R1", "samples in reset",
            {left_sample, right_sample}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check({bclk_out, ws_out, pair_valid} == 3'b000, "R1", "control outputs after reset",
            {29'h0, bclk_out, ws_out, pair_valid}, 32'h0);

      // master, short slots
      pair_tag = "R5/R6";
      do_reset(1'b1, 1'b0);
      run_master(12, 16);

      // master, long slots: upper half of each slot is random garbage
      pair_tag = "R7";
      word_idx = 0;
      do_reset(1'b1, 1'b1);
      run_master(10, 32);

      // slave, short slots, preamble with word select high then a change to left
      pair_tag = "R4/R5/R6";
      word_idx = 0;
      do_reset(1'b0, 1'b0);
      run_slave(12, 16, 1'b1);

      // slave, long slots, preamble with word select low
      pair_tag = "R7";
      do_reset(1'b0, 1'b0);
      run_slave(10, 32, 1'b0);

      // run-time switch from slave to master without reset
      pair_tag = "R9";
      tx_reset();
      exp_q.delete();
      master_en = 1'b1;
      long_slot = 1'b0;
      received  = 0;
      run_master(6, 16);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(150000 * CLK_NS);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule